// File: doc/BRIEF.md
# Asynchronous Memory Strobe Controller

This block drives an external asynchronous memory, such as an SRAM or a NOR flash, on up to `NCS` chip selects. A host hands it one read or write at a time. The block then runs the external access through a fixed sequence of phases: an address setup phase, a strobe phase (output enable for reads, write enable for writes) and a hold phase. Each chip select has its own phase lengths. A programmed count `N` gives a phase of `N+1` cycles. Between two accesses the block can insert a turnaround gap. The gap is skipped when the new access has the same direction and the same chip select as the previous one.

A wait input can stretch the strobe phase on chip selects that enable it, and its active level is programmable. If the wait input stays active too long, a timeout ends the access and sets a sticky interrupt flag. A separate sticky flag records rising edges on the wait input.

The request side is valid/ready. `req_ready` is high only while the controller is idle, so a request is taken in a cycle where both `req_valid` and `req_ready` are high. The host holds its request stable while `req_ready` is low. The response side has no back-pressure: `rsp_valid` is a one-cycle pulse and must be taken when it appears.

Top module: `amc_top`

## Requirements
- R1: After reset every chip select, output enable and write enable is inactive (high), `mem_rnw` is 1, both interrupt flags are 0 and `req_ready` is 1.
- R2: In the cycle after a read is accepted, its chip select goes low. It stays low with `mem_oe_n` high for RD_SETUP+1 cycles. Then `mem_oe_n` is low for RD_STROBE+1 cycles, then the chip select stays low for RD_HOLD+1 cycles with `mem_oe_n` high.
- R3: A write follows the same phase pattern using WR_SETUP, WR_STROBE and WR_HOLD, with `mem_we_n` as the strobe. During the whole access `mem_rnw` is 0, `mem_dout_en` is 1 and `mem_dout` carries the write data.
- R4: After the accept cycle, an access waits TURN cycles (the value for its own chip select) with all chip selects high. The wait applies only when the previous access had a different direction or a different chip select. Otherwise no cycles are added, and the first access after reset never waits.
- R5: `mem_din` is captured on the last strobe cycle of a read. `rsp_valid` pulses for one cycle, in the cycle after the hold phase ends, with the captured value on `rsp_rdata`.
- R6: `mem_be_n` is the inverse of `req_be` (bit i enables byte i). On a chip select whose strobe-byte-enable bit is 0, it is active for every cycle the chip select is low. When that bit is 1, it is active only during the strobe phase. At all other times it is all ones.
- R7: On a chip select with wait enabled, the strobe phase does not end while `mem_wait` equals `cfg_wait_pol` (1 means active high). The strobe therefore lasts max(STROBE+1, K) cycles when the wait input goes inactive during the K-th strobe cycle. With wait disabled, `mem_wait` has no effect.
- R8: If the wait input is still active in cycle (MAX+1)*16 counted from the last nominal strobe cycle, the strobe ends after that cycle. The strobe then lasts STROBE+(MAX+1)*16 cycles, and `irq_timeout` is set if `irq_en_timeout` is 1.
- R9: A 0-to-1 change of the raw `mem_wait` pin sets `irq_wait_rise` one clock later when `irq_en_wrise` is 1. It sets nothing when `irq_en_wrise` is 0.
- R10: Both flags hold until cleared. `irq_clr[0]` clears `irq_timeout` and `irq_clr[1]` clears `irq_wait_rise`. A new event in the same cycle takes priority over the clear.
- R11: `req_ready` is low from the accept until the response. At most one chip select is low at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Controller idle, request taken this cycle if valid |
| req_write | input | 1 | 1 write, 0 read |
| req_cs | input | CSW | Chip select index |
| req_addr | input | AW | Access address |
| req_wdata | input | DW | Write data |
| req_be | input | DW/8 | Byte enables, active high |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data captured at end of strobe |
| cfg_rd_setup | input | NCS*PW | Read setup count per chip select |
| cfg_rd_strobe | input | NCS*PW | Read strobe count per chip select |
| cfg_rd_hold | input | NCS*PW | Read hold count per chip select |
| cfg_wr_setup | input | NCS*PW | Write setup count per chip select |
| cfg_wr_strobe | input | NCS*PW | Write strobe count per chip select |
| cfg_wr_hold | input | NCS*PW | Write hold count per chip select |
| cfg_turn | input | NCS*TW | Turnaround cycles per chip select |
| cfg_strobe_be | input | NCS | 1 = byte enables only during strobe |
| cfg_wait_en | input | NCS | Wait extension enable per chip select |
| cfg_wait_pol | input | 1 | Active level of the wait input |
| cfg_max_wait | input | XW | Timeout count MAX (window (MAX+1)*16) |
| irq_en_timeout | input | 1 | Timeout flag enable |
| irq_en_wrise | input | 1 | Wait-rise flag enable |
| irq_clr | input | 2 | Write-one-to-clear: bit0 timeout, bit1 wait rise |
| irq_timeout | output | 1 | Sticky timeout flag |
| irq_wait_rise | output | 1 | Sticky wait-rise flag |
| mem_cs_n | output | NCS | Chip selects, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_rnw | output | 1 | 1 read, 0 write during access |
| mem_be_n | output | DW/8 | Byte enables, active low |
| mem_addr | output | AW | Address |
| mem_dout | output | DW | Write data |
| mem_dout_en | output | 1 | Data bus drive enable |
| mem_din | input | DW | Read data from memory |
| mem_wait | input | 1 | Wait input |

## Verification
The bench uses three chip selects, a 16-bit data bus with two byte lanes, 4-bit phase and turnaround counts and an 8-bit timeout count. Each chip select gets different phase lengths, and together they cover the zero-length (single-cycle) phases, the strobe-only byte-enable mode and a chip select with the wait extension turned off. Timeout counts of 0 and 1 give 16- and 32-cycle windows, so both the timeout length and the MAX-dependent scaling can be measured in short runs. With three chip selects, the turnaround rule can be checked separately for a change of chip select, a change of direction, and a repeat of the same direction on the same chip select.

// File: rtl/amc_pkg.sv
package amc_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_TURN,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } amc_state_e;
endpackage

// File: rtl/amc_cfg_sel.sv
module amc_cfg_sel #(
  parameter int NCS = 3,
  parameter int PW  = 4,
  parameter int TW  = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1
) (
  input  logic [CSW-1:0]    sel,
  input  logic              wr,
  input  logic [NCS*PW-1:0] rd_setup,
  input  logic [NCS*PW-1:0] rd_strobe,
  input  logic [NCS*PW-1:0] rd_hold,
  input  logic [NCS*PW-1:0] wr_setup,
  input  logic [NCS*PW-1:0] wr_strobe,
  input  logic [NCS*PW-1:0] wr_hold,
  input  logic [NCS*TW-1:0] turn,
  input  logic [NCS-1:0]    strobe_be,
  input  logic [NCS-1:0]    wait_en,
  output logic [PW-1:0]     o_setup,
  output logic [PW-1:0]     o_strobe,
  output logic [PW-1:0]     o_hold,
  output logic [TW-1:0]     o_turn,
  output logic              o_strobe_be,
  output logic              o_wait_en
);
  logic [PW-1:0] rs [NCS], rst [NCS], rh [NCS];
  logic [PW-1:0] ws [NCS], wst [NCS], wh [NCS];
  logic [TW-1:0] ta [NCS];

  for (genvar i = 0; i < NCS; i++) begin : g_unpack
    assign rs[i]  = rd_setup [i*PW +: PW];
    assign rst[i] = rd_strobe[i*PW +: PW];
    assign rh[i]  = rd_hold  [i*PW +: PW];
    assign ws[i]  = wr_setup [i*PW +: PW];
    assign wst[i] = wr_strobe[i*PW +: PW];
    assign wh[i]  = wr_hold  [i*PW +: PW];
    assign ta[i]  = turn     [i*TW +: TW];
  end

  int idx;
  always_comb begin
    idx = (int'(sel) < NCS) ? int'(sel) : 0;
    o_setup     = wr ? ws[idx]  : rs[idx];
    o_strobe    = wr ? wst[idx] : rst[idx];
    o_hold      = wr ? wh[idx]  : rh[idx];
    o_turn      = ta[idx];
    o_strobe_be = strobe_be[idx];
    o_wait_en   = wait_en[idx];
  end
endmodule

// File: rtl/amc_wait_mon.sv
module amc_wait_mon #(
  parameter int XW = 8,
  localparam int WW = XW + 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wait_pin,
  input  logic          wait_pol,
  input  logic          ext_en,
  input  logic          strobe_end,
  input  logic [XW-1:0] max_wait,
  input  logic          en_timeout,
  input  logic          en_rise,
  input  logic [1:0]    clr,
  output logic          stall,
  output logic          irq_timeout,
  output logic          irq_rise
);
  logic [WW-1:0] wcnt;
  logic          wait_q;
  logic          holding;
  logic          limit_hit;
  logic          timeout_ev;
  logic          rise_ev;

  assign holding    = strobe_end && ext_en && (wait_pin == wait_pol);
  assign limit_hit  = (wcnt == {max_wait, 4'hF});
  assign stall      = holding && !limit_hit;
  assign timeout_ev = holding && limit_hit;
  assign rise_ev    = wait_pin && !wait_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wcnt        <= '0;
      wait_q      <= 1'b0;
      irq_timeout <= 1'b0;
      irq_rise    <= 1'b0;
    end else begin
      wait_q <= wait_pin;
      wcnt   <= stall ? wcnt + 1'b1 : '0;
      if (timeout_ev && en_timeout) irq_timeout <= 1'b1;
      else if (clr[0])              irq_timeout <= 1'b0;
      if (rise_ev && en_rise)       irq_rise <= 1'b1;
      else if (clr[1])              irq_rise <= 1'b0;
    end
  end

  p_timeout_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_timeout && !clr[0]) |=> irq_timeout);
  p_rise_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_rise && !clr[1]) |=> irq_rise);
  p_stall_needs_wait_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |-> (ext_en && wait_pin == wait_pol));
endmodule

// File: rtl/amc_seq.sv
module amc_seq
  import amc_pkg::*;
#(
  parameter int NCS = 3,
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int PW  = 4,
  parameter int TW  = 4,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BW  = DW / 8,
  localparam int CW  = (PW > TW) ? PW : TW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req_valid,
  output logic           req_ready,
  input  logic           req_write,
  input  logic [CSW-1:0] req_cs,
  input  logic [AW-1:0]  req_addr,
  input  logic [DW-1:0]  req_wdata,
  input  logic [BW-1:0]  req_be,
  output logic           rsp_valid,
  output logic [DW-1:0]  rsp_rdata,
  input  logic [PW-1:0]  c_setup,
  input  logic [PW-1:0]  c_strobe,
  input  logic [PW-1:0]  c_hold,
  input  logic [TW-1:0]  c_turn,
  input  logic           c_strobe_be,
  input  logic           stall,
  output logic [CSW-1:0] sel_cs,
  output logic           sel_wr,
  output logic           strobe_end,
  output logic [NCS-1:0] mem_cs_n,
  output logic           mem_oe_n,
  output logic           mem_we_n,
  output logic           mem_rnw,
  output logic [BW-1:0]  mem_be_n,
  output logic [AW-1:0]  mem_addr,
  output logic [DW-1:0]  mem_dout,
  output logic           mem_dout_en,
  input  logic [DW-1:0]  mem_din
);
  amc_state_e     state;
  logic [CW-1:0]  cnt;
  logic [CSW-1:0] cur_cs, last_cs;
  logic           cur_wr, last_wr, have_last;
  logic [AW-1:0]  cur_addr;
  logic [DW-1:0]  cur_wdata;
  logic [BW-1:0]  cur_be;
  logic           accept, need_turn, active, cnt_zero;

  assign req_ready  = (state == ST_IDLE);
  assign accept     = req_valid && req_ready;
  assign sel_cs     = req_ready ? req_cs : cur_cs;
  assign sel_wr     = req_ready ? req_write : cur_wr;
  assign cnt_zero   = (cnt == '0);
  assign strobe_end = (state == ST_STROBE) && cnt_zero;
  assign need_turn  = have_last && ((req_cs != last_cs) || (req_write != last_wr))
                      && (c_turn != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      cnt       <= '0;
      cur_cs    <= '0;
      last_cs   <= '0;
      cur_wr    <= 1'b0;
      last_wr   <= 1'b0;
      have_last <= 1'b0;
      cur_addr  <= '0;
      cur_wdata <= '0;
      cur_be    <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= 1'b0;
      unique case (state)
        ST_IDLE: if (accept) begin
          cur_cs    <= req_cs;
          cur_wr    <= req_write;
          cur_addr  <= req_addr;
          cur_wdata <= req_wdata;
          cur_be    <= req_be;
          last_cs   <= req_cs;
          last_wr   <= req_write;
          have_last <= 1'b1;
          if (need_turn) begin
            state <= ST_TURN;
            cnt   <= CW'(c_turn - 1'b1);
          end else begin
            state <= ST_SETUP;
            cnt   <= CW'(c_setup);
          end
        end
        ST_TURN: if (cnt_zero) begin
          state <= ST_SETUP;
          cnt   <= CW'(c_setup);
        end else cnt <= cnt - 1'b1;
        ST_SETUP: if (cnt_zero) begin
          state <= ST_STROBE;
          cnt   <= CW'(c_strobe);
        end else cnt <= cnt - 1'b1;
        ST_STROBE: if (!cnt_zero) cnt <= cnt - 1'b1;
          else if (!stall) begin
            rsp_rdata <= mem_din;
            state     <= ST_HOLD;
            cnt       <= CW'(c_hold);
          end
        ST_HOLD: if (cnt_zero) begin
          state     <= ST_IDLE;
          rsp_valid <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    active      = (state == ST_SETUP) || (state == ST_STROBE) || (state == ST_HOLD);
    mem_cs_n    = active ? ~(NCS'(1) << cur_cs) : '1;
    mem_oe_n    = !((state == ST_STROBE) && !cur_wr);
    mem_we_n    = !((state == ST_STROBE) && cur_wr);
    mem_rnw     = !(active && cur_wr);
    mem_be_n    = (active && (!c_strobe_be || state == ST_STROBE)) ? ~cur_be : '1;
    mem_addr    = cur_addr;
    mem_dout    = cur_wdata;
    mem_dout_en = active && cur_wr;
  end

  p_one_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~mem_cs_n));
  p_ready_no_cs_r11: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&mem_cs_n));
  p_strobe_excl_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(!mem_oe_n && !mem_we_n));
  p_setup_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(&mem_cs_n) |-> (mem_oe_n && mem_we_n));
  p_rsp_after_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(state == ST_HOLD) && (&mem_cs_n)));
endmodule

// File: rtl/amc_top.sv
module amc_top #(
  parameter int NCS = 3,
  parameter int AW  = 20,
  parameter int DW  = 16,
  parameter int PW  = 4,
  parameter int TW  = 4,
  parameter int XW  = 8,
  localparam int CSW = (NCS > 1) ? $clog2(NCS) : 1,
  localparam int BW  = DW / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [CSW-1:0]    req_cs,
  input  logic [AW-1:0]     req_addr,
  input  logic [DW-1:0]     req_wdata,
  input  logic [BW-1:0]     req_be,
  output logic              rsp_valid,
  output logic [DW-1:0]     rsp_rdata,
  input  logic [NCS*PW-1:0] cfg_rd_setup,
  input  logic [NCS*PW-1:0] cfg_rd_strobe,
  input  logic [NCS*PW-1:0] cfg_rd_hold,
  input  logic [NCS*PW-1:0] cfg_wr_setup,
  input  logic [NCS*PW-1:0] cfg_wr_strobe,
  input  logic [NCS*PW-1:0] cfg_wr_hold,
  input  logic [NCS*TW-1:0] cfg_turn,
  input  logic [NCS-1:0]    cfg_strobe_be,
  input  logic [NCS-1:0]    cfg_wait_en,
  input  logic              cfg_wait_pol,
  input  logic [XW-1:0]     cfg_max_wait,
  input  logic              irq_en_timeout,
  input  logic              irq_en_wrise,
  input  logic [1:0]        irq_clr,
  output logic              irq_timeout,
  output logic              irq_wait_rise,
  output logic [NCS-1:0]    mem_cs_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  output logic              mem_rnw,
  output logic [BW-1:0]     mem_be_n,
  output logic [AW-1:0]     mem_addr,
  output logic [DW-1:0]     mem_dout,
  output logic              mem_dout_en,
  input  logic [DW-1:0]     mem_din,
  input  logic              mem_wait
);
  logic [CSW-1:0] sel_cs;
  logic           sel_wr, strobe_end, stall, c_strobe_be, c_wait_en;
  logic [PW-1:0]  c_setup, c_strobe, c_hold;
  logic [TW-1:0]  c_turn;

  amc_cfg_sel #(.NCS(NCS), .PW(PW), .TW(TW)) u_cfg (
    .sel(sel_cs), .wr(sel_wr),
    .rd_setup(cfg_rd_setup), .rd_strobe(cfg_rd_strobe), .rd_hold(cfg_rd_hold),
    .wr_setup(cfg_wr_setup), .wr_strobe(cfg_wr_strobe), .wr_hold(cfg_wr_hold),
    .turn(cfg_turn), .strobe_be(cfg_strobe_be), .wait_en(cfg_wait_en),
    .o_setup(c_setup), .o_strobe(c_strobe), .o_hold(c_hold), .o_turn(c_turn),
    .o_strobe_be(c_strobe_be), .o_wait_en(c_wait_en)
  );

  amc_seq #(.NCS(NCS), .AW(AW), .DW(DW), .PW(PW), .TW(TW)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_cs(req_cs), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .c_setup(c_setup), .c_strobe(c_strobe), .c_hold(c_hold), .c_turn(c_turn),
    .c_strobe_be(c_strobe_be), .stall(stall),
    .sel_cs(sel_cs), .sel_wr(sel_wr), .strobe_end(strobe_end),
    .mem_cs_n(mem_cs_n), .mem_oe_n(mem_oe_n), .mem_we_n(mem_we_n),
    .mem_rnw(mem_rnw), .mem_be_n(mem_be_n), .mem_addr(mem_addr),
    .mem_dout(mem_dout), .mem_dout_en(mem_dout_en), .mem_din(mem_din)
  );

  amc_wait_mon #(.XW(XW)) u_wait (
    .clk(clk), .rst_n(rst_n),
    .wait_pin(mem_wait), .wait_pol(cfg_wait_pol), .ext_en(c_wait_en),
    .strobe_end(strobe_end), .max_wait(cfg_max_wait),
    .en_timeout(irq_en_timeout), .en_rise(irq_en_wrise), .clr(irq_clr),
    .stall(stall), .irq_timeout(irq_timeout), .irq_rise(irq_wait_rise)
  );

  p_stall_keeps_strobe_r7: assert property (@(posedge clk) disable iff (!rst_n)
    stall |=> $stable(mem_cs_n) && $stable(mem_oe_n) && $stable(mem_we_n));
endmodule

// File: tb/tb_amc_top.sv
module tb_amc_top;
  localparam int NCS = 3, AW = 20, DW = 16, PW = 4, TW = 4, XW = 8;
  localparam int CSW = 2, BW = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic req_valid = 0, req_write = 0;
  logic [CSW-1:0] req_cs = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic [BW-1:0] req_be = '0;
  logic req_ready, rsp_valid;
  logic [DW-1:0] rsp_rdata;
  // per chip select: cs2 | cs1 | cs0
  logic [NCS*PW-1:0] cfg_rd_setup  = {4'd2, 4'd0, 4'd1};
  logic [NCS*PW-1:0] cfg_rd_strobe = {4'd1, 4'd0, 4'd2};
  logic [NCS*PW-1:0] cfg_rd_hold   = {4'd2, 4'd0, 4'd1};
  logic [NCS*PW-1:0] cfg_wr_setup  = {4'd1, 4'd2, 4'd0};
  logic [NCS*PW-1:0] cfg_wr_strobe = {4'd1, 4'd3, 4'd1};
  logic [NCS*PW-1:0] cfg_wr_hold   = {4'd1, 4'd1, 4'd0};
  logic [NCS*TW-1:0] cfg_turn      = {4'd1, 4'd3, 4'd2};
  logic [NCS-1:0] cfg_strobe_be = 3'b100;
  logic [NCS-1:0] cfg_wait_en   = 3'b101;
  logic cfg_wait_pol = 1'b1;
  logic [XW-1:0] cfg_max_wait = '0;
  logic irq_en_timeout = 0, irq_en_wrise = 0;
  logic [1:0] irq_clr = '0;
  logic irq_timeout, irq_wait_rise;
  logic [NCS-1:0] mem_cs_n;
  logic mem_oe_n, mem_we_n, mem_rnw, mem_dout_en;
  logic [BW-1:0] mem_be_n;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_dout;
  logic [DW-1:0] mem_din = '0;
  logic mem_wait = 1'b0;

  amc_top #(.NCS(NCS), .AW(AW), .DW(DW), .PW(PW), .TW(TW), .XW(XW)) dut (.*);

  int n_run = 0, n_fail = 0;
  int pre_n, setup_n, strobe_n, hold_n, be_n_cyc;
  logic [DW-1:0] cap;
  bit bus_ok, ready_ok;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d (0x%0h) expected %0d (0x%0h)", req, act, act, exp, exp);
    end
  endtask

  // Caller is at a negedge with the controller idle.
  task automatic access(input int cs, input bit wr, input logic [DW-1:0] wd,
                        input logic [BW-1:0] be, input int wk, input bit wlvl);
    int cyc = 0;
    pre_n = 0; setup_n = 0; strobe_n = 0; hold_n = 0; be_n_cyc = 0;
    bus_ok = 1; ready_ok = 1; cap = '0;
    req_valid = 1; req_write = wr; req_cs = CSW'(cs); req_addr = AW'(20'h1234 + cs);
    req_wdata = wd; req_be = be;
    if (wk >= 0) mem_wait = wlvl;
    @(posedge clk);
    forever begin
      @(negedge clk);
      req_valid = 0;
      cyc++;
      if (rsp_valid || cyc > 400) break;
      mem_din = DW'(16'hC000 + cyc);
      if (req_ready) ready_ok = 0;
      if (&mem_cs_n) begin
        if (setup_n == 0 && strobe_n == 0) pre_n++;
      end else if (mem_cs_n[cs] == 1'b0) begin
        if (mem_addr != AW'(20'h1234 + cs)) bus_ok = 0;
        if (wr && (mem_rnw || !mem_dout_en || mem_dout != wd)) bus_ok = 0;
        if (!wr && (!mem_rnw || mem_dout_en)) bus_ok = 0;
        if (mem_be_n == ~be) be_n_cyc++;
        else if (mem_be_n != '1) bus_ok = 0;
        if ((wr ? mem_we_n : mem_oe_n) == 1'b0) begin
          strobe_n++;
          cap = mem_din;
          if (wk >= 0 && strobe_n >= wk) mem_wait = ~wlvl;
        end else if (strobe_n == 0) setup_n++;
        else hold_n++;
      end else bus_ok = 0;
    end
    if (wk >= 0) mem_wait = ~wlvl;
  endtask

  task automatic t_reset();
    check(mem_cs_n == 3'b111 && mem_oe_n && mem_we_n && mem_rnw, "R1 pins idle", mem_cs_n, 7);
    check(!irq_timeout && !irq_wait_rise, "R1 flags clear", {irq_timeout, irq_wait_rise}, 0);
    check(req_ready, "R1 ready", req_ready, 1);
  endtask

  task automatic t_read_timing();
    access(0, 0, '0, 2'b11, -1, 1);
    check(pre_n == 0, "R4 first access no gap", pre_n, 0);
    check(setup_n == 2, "R2 read setup", setup_n, 2);
    check(strobe_n == 3, "R2 read strobe", strobe_n, 3);
    check(hold_n == 2, "R2 read hold", hold_n, 2);
    check(rsp_rdata == cap, "R5 read capture", rsp_rdata, cap);
    check(be_n_cyc == 7, "R6 normal be whole access", be_n_cyc, 7);
    check(ready_ok, "R11 ready low during access", ready_ok, 1);
  endtask

  task automatic t_write_timing();
    access(1, 1, 16'h5A3C, 2'b11, -1, 1);
    check(pre_n == 3, "R4 cs+dir change gap", pre_n, 3);
    check(setup_n == 3 && strobe_n == 4 && hold_n == 2, "R3 write phases",
          setup_n*100 + strobe_n*10 + hold_n, 342);
    check(bus_ok, "R3 write bus", bus_ok, 1);
  endtask

  task automatic t_turnaround();
    access(1, 1, 16'h0F0F, 2'b11, -1, 1);
    check(pre_n == 0, "R4 write-write same cs", pre_n, 0);
    access(1, 0, '0, 2'b11, -1, 1);
    check(pre_n == 3, "R4 dir change", pre_n, 3);
    check(setup_n == 1 && strobe_n == 1 && hold_n == 1, "R2 zero counts",
          setup_n*100 + strobe_n*10 + hold_n, 111);
    access(2, 0, '0, 2'b10, -1, 1);
    check(pre_n == 1, "R4 cs change", pre_n, 1);
    check(be_n_cyc == 2 && strobe_n == 2, "R6 strobe-mode be", be_n_cyc, 2);
    check(bus_ok, "R6 be pattern", bus_ok, 1);
    access(2, 0, '0, 2'b11, -1, 1);
    check(pre_n == 0, "R4 read-read same cs", pre_n, 0);
  endtask

  task automatic t_byte_partial();
    access(0, 1, 16'h00AB, 2'b01, -1, 1);
    check(pre_n == 2, "R4 gap uses new cs", pre_n, 2);
    check(be_n_cyc == 4 && bus_ok, "R6 partial be normal", be_n_cyc, 4);
  endtask

  task automatic t_wait();
    access(0, 0, '0, 2'b11, 6, 1);
    check(strobe_n == 6, "R7 wait stretch", strobe_n, 6);
    access(0, 0, '0, 2'b11, 2, 1);
    check(strobe_n == 3, "R7 early release", strobe_n, 3);
    access(1, 0, '0, 2'b11, 1000, 1);
    check(strobe_n == 1, "R7 wait ignored when disabled", strobe_n, 1);
    mem_wait = 1'b1; cfg_wait_pol = 1'b0;
    access(2, 0, '0, 2'b11, 5, 0);
    check(strobe_n == 5, "R7 active-low wait", strobe_n, 5);
    check(rsp_rdata == cap, "R5 capture after wait", rsp_rdata, cap);
    mem_wait = 1'b0; cfg_wait_pol = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_timeout();
    irq_en_timeout = 1; cfg_max_wait = 8'd0;
    access(0, 0, '0, 2'b11, 1000, 1);
    check(strobe_n == 18, "R8 timeout window 16", strobe_n, 18);
    check(irq_timeout, "R8 timeout flag", irq_timeout, 1);
    repeat (3) @(negedge clk);
    check(irq_timeout, "R10 flag sticky", irq_timeout, 1);
    irq_clr = 2'b10;
    @(negedge clk);
    check(irq_timeout, "R10 other clear bit", irq_timeout, 1);
    irq_clr = 2'b01;
    @(negedge clk);
    irq_clr = 2'b00;
    check(!irq_timeout, "R10 clear timeout", irq_timeout, 0);
    irq_en_timeout = 0; cfg_max_wait = 8'd1;
    access(0, 0, '0, 2'b11, 1000, 1);
    check(strobe_n == 34, "R8 timeout window 32", strobe_n, 34);
    check(!irq_timeout, "R8 flag gated off", irq_timeout, 0);
  endtask

  task automatic t_rise();
    check(!irq_wait_rise, "R9 no flag while disabled", irq_wait_rise, 0);
    irq_en_wrise = 1; mem_wait = 0;
    @(negedge clk); mem_wait = 1;
    @(negedge clk);
    check(irq_wait_rise, "R9 rise sets flag", irq_wait_rise, 1);
    mem_wait = 0; irq_clr = 2'b10;
    @(negedge clk); irq_clr = 2'b00;
    check(!irq_wait_rise, "R10 clear rise", irq_wait_rise, 0);
    irq_en_wrise = 0;
    @(negedge clk); mem_wait = 1;
    @(negedge clk); @(negedge clk);
    check(!irq_wait_rise, "R9 disabled rise ignored", irq_wait_rise, 0);
    mem_wait = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_read_timing();
    t_write_timing();
    t_turnaround();
    t_byte_partial();
    t_wait();
    t_timeout();
    t_rise();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_run++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule